// File: doc/BRIEF.md
# Flash Sector Protection Checker

This block stands between the command path and the flash array and decides, for every program, erase or mass-erase request, whether the operation may go ahead. It keeps an 8-bit protection register. At reset the register is loaded from a configuration byte on an input port, which stands for a fixed nonvolatile location. Software may rewrite the register afterwards, within fixed rules. The register describes one window at the top of the address space and one window at a fixed low base. A polarity bit sets whether the enabled windows are the protected areas or the only unprotected areas.

A request arrives as a one-cycle strobe with a kind and an address. One cycle later the block answers with either a grant or a reject. A reject also sets a sticky violation flag. Software clears that flag by writing a one to its bit in a status write port. A mass erase is refused whenever any part of the array is protected.

Top module: `flash_guard`

## Requirements
- R1: On reset the protection register takes the value of `cfg_byte`, except that bit 6 always reads 1. After reset, `resp_valid` and `viol_flag` are 0.
- R2: Bit 6 of the register is reserved. It reads 1 at all times, and writes to it have no effect.
- R3: Bit 7 (polarity), bit 5 (high-window disable) and bit 2 (low-window disable) take the written value on any register write.
- R4: Bits 4:3 (high-window size) are updated by a write only when the stored bit 5 is already 1 before that write. Otherwise they keep their value.
- R5: Bits 1:0 (low-window size) are updated by a write only when the stored bit 2 is already 1 before that write. Otherwise they keep their value.
- R6: When bit 5 is 0, the high window covers the top 2K, 4K, 8K or 16K bytes of the 16-bit space, for size codes 0 to 3. For example, code 3 covers 0xC000 to 0xFFFF.
- R7: When bit 2 is 0, the low window starts at 0x4000 and covers 512, 1K, 2K or 4K bytes, for size codes 0 to 3.
- R8: With polarity 1, an address is protected if and only if it lies in an enabled window. With polarity 0, an address is protected if and only if it lies in no enabled window. It follows that polarity 0 with both windows disabled protects everything, and polarity 1 with both windows disabled protects nothing.
- R9: The kind encoding is 00 program, 01 erase, 10 mass erase, and 11 is handled like erase. A program or erase request is answered one cycle after its strobe with `resp_valid`=1. Exactly one of `resp_grant` or `resp_reject` is set, and reject is chosen when the address is protected.
- R10: A mass erase is rejected if any address is protected. That is the case when polarity is 0, or when polarity is 1 and at least one window is enabled. Otherwise it is granted.
- R11: A reject sets `viol_flag` in the same cycle that `resp_reject` is shown. The flag stays set until a status write with bit 5 = 1. A status write with bit 5 = 0 has no effect. If a reject and a clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Nonvolatile protection byte loaded at reset |
| prot_wr | input | 1 | Protection register write strobe |
| prot_wdata | input | 8 | Protection register write data |
| prot_rdata | output | 8 | Current protection register value |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data; bit 5 = 1 clears the violation flag |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 00 program, 01 erase, 10 mass erase, 11 erase |
| req_addr | input | 16 | Target byte address |
| resp_valid | output | 1 | Result valid, one cycle after the request |
| resp_grant | output | 1 | Operation allowed |
| resp_reject | output | 1 | Operation blocked |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
The bench probes the first and last byte of each window, and the byte just outside each window, for several size codes. An off-by-one window bound shows up as a wrong grant on one of those bytes.

Writes to the size fields are tried both while the window is enabled and while it is disabled. A design that checks the new disable bit instead of the stored one, or that lets size writes through unconditionally, reads back different size bits.

Both polarities are run with both windows disabled, which separates the "everything protected" case from the "nothing protected" case for mass erase. A reject and a flag clear are also driven in the same cycle, so a design that lets the clear win loses the flag.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    K_PROG  = 2'b00,
    K_ERASE = 2'b01,
    K_MASS  = 2'b10,
    K_RSVD  = 2'b11
  } req_kind_e;

  typedef struct packed {
    logic       pol;     // 1: windows protected, 0: windows unprotected
    logic       rsv;     // reserved, reads 1
    logic       hi_dis;
    logic [1:0] hi_sz;
    logic       lo_dis;
    logic [1:0] lo_sz;
  } prot_t;

  // size in bytes of a window with the given smallest log2 size and code
  function automatic int win_bytes(input int min_log, input logic [1:0] code);
    return 1 << (min_log + int'(code));
  endfunction

  // window that ends at the top of a space of 'space' bytes
  function automatic logic top_hit(input int addr, input int space, input int bytes);
    return addr >= (space - bytes);
  endfunction

  // window starting at a fixed base
  function automatic logic base_hit(input int addr, input int base, input int bytes);
    return (addr >= base) && (addr < base + bytes);
  endfunction

endpackage

// File: rtl/fg_prot_reg.sv
module fg_prot_reg
  import fg_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cfg_byte,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output prot_t            prot_q,
  output logic             hi_sz_open,
  output logic             lo_sz_open
);

  prot_t wr_view;
  prot_t nxt;

  assign wr_view    = prot_t'(wr_data);
  assign hi_sz_open = prot_q.hi_dis;
  assign lo_sz_open = prot_q.lo_dis;

  always_comb begin
    nxt        = prot_q;
    nxt.pol    = wr_view.pol;
    nxt.hi_dis = wr_view.hi_dis;
    nxt.lo_dis = wr_view.lo_dis;
    if (hi_sz_open) nxt.hi_sz = wr_view.hi_sz;
    if (lo_sz_open) nxt.lo_sz = wr_view.lo_sz;
    nxt.rsv    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q     <= prot_t'(cfg_byte);
      prot_q.rsv <= 1'b1;
    end else if (wr_en) begin
      prot_q <= nxt;
    end
  end

  a_r2_rsv_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prot_q.rsv == 1'b1);

  a_r4_hi_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_q.hi_dis |=> $stable(prot_q.hi_sz));

  a_r5_lo_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_q.lo_dis |=> $stable(prot_q.lo_sz));

  a_r3_pol_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> prot_q.pol == $past(wr_data[REG_W-1]));

endmodule

// File: rtl/fg_window_decode.sv
module fg_window_decode
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int HI_MIN_LOG = 11,
  parameter int LO_MIN_LOG = 9,
  parameter int LO_BASE    = 'h4000
) (
  input  prot_t             prot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  output logic              hi_hit,
  output logic              lo_hit,
  output logic              addr_prot,
  output logic              any_prot,
  output logic              blocked
);

  localparam int SPACE = 1 << ADDR_W;

  int addr_i;
  logic in_window;

  always_comb begin
    addr_i    = int'(addr);
    hi_hit    = !prot.hi_dis && top_hit(addr_i, SPACE, win_bytes(HI_MIN_LOG, prot.hi_sz));
    lo_hit    = !prot.lo_dis && base_hit(addr_i, LO_BASE, win_bytes(LO_MIN_LOG, prot.lo_sz));
    in_window = hi_hit || lo_hit;
    addr_prot = prot.pol ? in_window : !in_window;
    // with polarity 0 the windows never span the whole array
    any_prot  = prot.pol ? (!prot.hi_dis || !prot.lo_dis) : 1'b1;
    blocked   = (kind == K_MASS) ? any_prot : addr_prot;
  end

endmodule

// File: rtl/fg_resp.sv
module fg_resp #(
  parameter int STAT_W   = 8,
  parameter int VIOL_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              blocked,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_reject,
  output logic              viol_flag
);

  logic viol_set;
  logic viol_clr;

  assign viol_set = req_valid && blocked;
  assign viol_clr = stat_wr && stat_wdata[VIOL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_grant  <= 1'b0;
      resp_reject <= 1'b0;
      viol_flag   <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_grant  <= req_valid && !blocked;
      resp_reject <= viol_set;
      if (viol_set)      viol_flag <= 1'b1;
      else if (viol_clr) viol_flag <= 1'b0;
    end
  end

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_grant ^ resp_reject));

  a_r9_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r11_reject_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_reject |-> viol_flag);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int HI_MIN_LOG = 11,
  parameter int LO_MIN_LOG = 9,
  parameter int LO_BASE    = 'h4000,
  parameter int VIOL_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  cfg_byte,
  input  logic              prot_wr,
  input  logic [REG_W-1:0]  prot_wdata,
  output logic [REG_W-1:0]  prot_rdata,
  input  logic              stat_wr,
  input  logic [REG_W-1:0]  stat_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_reject,
  output logic              viol_flag
);

  prot_t prot_q;
  logic  hi_sz_open, lo_sz_open;
  logic  hi_hit, lo_hit, addr_prot, any_prot, blocked;

  fg_prot_reg #(.REG_W(REG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_byte  (cfg_byte),
    .wr_en     (prot_wr),
    .wr_data   (prot_wdata),
    .prot_q    (prot_q),
    .hi_sz_open(hi_sz_open),
    .lo_sz_open(lo_sz_open)
  );

  fg_window_decode #(
    .ADDR_W    (ADDR_W),
    .HI_MIN_LOG(HI_MIN_LOG),
    .LO_MIN_LOG(LO_MIN_LOG),
    .LO_BASE   (LO_BASE)
  ) u_dec (
    .prot     (prot_q),
    .addr     (req_addr),
    .kind     (req_kind),
    .hi_hit   (hi_hit),
    .lo_hit   (lo_hit),
    .addr_prot(addr_prot),
    .any_prot (any_prot),
    .blocked  (blocked)
  );

  fg_resp #(.STAT_W(REG_W), .VIOL_BIT(VIOL_BIT)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .blocked    (blocked),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .resp_reject(resp_reject),
    .viol_flag  (viol_flag)
  );

  assign prot_rdata = REG_W'(prot_q);

  a_r10_mass_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_MASS && prot_q.pol && prot_q.hi_dis && prot_q.lo_dis)
    |=> resp_grant);

  a_r8_pol0_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_q.pol && prot_q.hi_dis && prot_q.lo_dis) |=> resp_reject);

  a_r8_hit_pol1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != K_MASS && prot_q.pol && (hi_hit || lo_hit)) |=> resp_reject);

endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_byte = 8'hA4;
  logic        prot_wr = 1'b0;
  logic [7:0]  prot_wdata = 8'h00;
  logic [7:0]  prot_rdata;
  logic        stat_wr = 1'b0;
  logic [7:0]  stat_wdata = 8'h00;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = 16'h0000;
  logic        resp_valid, resp_grant, resp_reject, viol_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
    .prot_wr(prot_wr), .prot_wdata(prot_wdata), .prot_rdata(prot_rdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_grant(resp_grant),
    .resp_reject(resp_reject), .viol_flag(viol_flag)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_prot(input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    prot_wr = 1'b1; prot_wdata = d;
    @(negedge clk);
    prot_wr = 1'b0;
    check(tag, {8'h00, prot_rdata}, {8'h00, exp});
  endtask

  // exp_grant: 1 grant, 0 reject; flag is checked to be set after a reject
  task automatic do_req(input logic [1:0] k, input logic [15:0] a,
                        input logic exp_grant, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {13'b0, resp_valid, resp_grant, resp_reject}, {13'b0, 1'b1, exp_grant, !exp_grant});
    if (!exp_grant) check({tag, " flag"}, {15'b0, viol_flag}, 16'd1);
  endtask

  task automatic clear_flag(input logic [7:0] d, input logic exp_flag, input string tag);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 1'b0;
    check(tag, {15'b0, viol_flag}, {15'b0, exp_flag});
  endtask

  task automatic t_reset();
    // R1: cfg 0xA4 with bit 6 clear reads back 0xE4
    check("R1 reset value", {8'h00, prot_rdata}, 16'h00E4);
    check("R1 reset resp", {14'b0, resp_valid, viol_flag}, 16'd0);
    // R10 with pol 1 and both windows off: mass erase allowed
    do_req(2'b10, 16'h0000, 1'b1, "R10 mass open");
    do_req(2'b00, 16'hFFFF, 1'b1, "R8 pol1 none");
  endtask

  task automatic t_windows_pol1();
    // R3 R4 R5: sizes open because both disables are stored as 1
    wr_prot(8'h98, 8'hD8, "R4 R5 open size write");
    do_req(2'b00, 16'hC000, 1'b0, "R6 hi 16K first");
    clear_flag(8'h20, 1'b0, "R11 clear");
    do_req(2'b00, 16'hBFFF, 1'b1, "R6 hi 16K below");
    do_req(2'b00, 16'h41FF, 1'b0, "R7 lo 512 last");
    do_req(2'b01, 16'h4200, 1'b1, "R7 lo 512 after");
    do_req(2'b11, 16'h3FFF, 1'b1, "R7 lo below base");
    do_req(2'b10, 16'h0000, 1'b0, "R10 mass pol1 window");
  endtask

  task automatic t_locked();
    // R2 R4 R5: windows enabled, size and reserved writes ignored
    wr_prot(8'h03, 8'h58, "R4 R5 R2 locked sizes");
    wr_prot(8'h83, 8'hD8, "R3 pol back");
  endtask

  task automatic t_flag();
    clear_flag(8'h00, 1'b1, "R11 no-clear write");
    clear_flag(8'hDF, 1'b1, "R11 other bits");
    clear_flag(8'h20, 1'b0, "R11 clear bit");
    // reject and clear in the same cycle: flag stays set
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'hFFFF;
    stat_wr = 1'b1; stat_wdata = 8'h20;
    @(negedge clk);
    req_valid = 1'b0; stat_wr = 1'b0;
    check("R11 set wins", {14'b0, resp_reject, viol_flag}, 16'd3);
    clear_flag(8'h20, 1'b0, "R11 clear again");
  endtask

  task automatic t_pol0();
    wr_prot(8'h18, 8'h58, "R3 pol0");
    do_req(2'b00, 16'hD000, 1'b1, "R8 pol0 hi open");
    do_req(2'b00, 16'h8000, 1'b0, "R8 pol0 outside");
    do_req(2'b01, 16'h4100, 1'b1, "R8 pol0 lo open");
    do_req(2'b10, 16'hC000, 1'b0, "R10 mass pol0");
    wr_prot(8'h24, 8'h7C, "R3 pol0 both off");
    do_req(2'b00, 16'hC000, 1'b0, "R8 pol0 all closed");
    do_req(2'b10, 16'h0000, 1'b0, "R10 mass pol0 off");
    clear_flag(8'h20, 1'b0, "R11 clear pol0");
  endtask

  task automatic t_resize();
    wr_prot(8'hAE, 8'hEE, "R4 R5 resize while off");
    wr_prot(8'h8A, 8'hCA, "R4 R5 enable keep size");
    do_req(2'b00, 16'hF000, 1'b0, "R6 hi 4K first");
    do_req(2'b00, 16'hEFFF, 1'b1, "R6 hi 4K below");
    do_req(2'b00, 16'h47FF, 1'b0, "R7 lo 2K last");
    do_req(2'b00, 16'h4800, 1'b1, "R7 lo 2K after");
    do_req(2'b01, 16'hF800, 1'b0, "R9 erase protected");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_windows_pol1();
    t_locked();
    t_flag();
    t_pol0();
    t_resize();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule